// File: doc/BRIEF.md
# Quad Prescaled Countdown Timer

This block holds four countdown timers, all alike and all clocked by the bus clock. Software programs each timer through a 32-bit register interface. Each timer has one control register and one count register. A timer runs for a period of (prescale+1)*(count+1) bus clocks. At the end of that period it raises a one-cycle interrupt request on the source line assigned to it. After that it either starts a new period at once or stops and clears its own enable bit.

The timers are started and stopped by edges of the enable bit in a control write. A write that leaves the enable bit as it was does not disturb a running period. The prescale and count fields can be rewritten while a timer runs. The new values are held until the next start or reload, so the period in progress finishes with the values it started with.

Top module: `quad_countdown_timer`

## Requirements
- R1: After reset every control register reads 0x0000FF00 (prescale all ones, timer disabled), every count register reads 0, and no interrupt line is high.
- R2: The bus uses word addresses. Word 2k is the control register of timer k and word 2k+1 is its count register. The control register keeps bit 0 (enable), bit 1 (auto-reload) and bits 15:8 (prescale), and all its other bits read zero. The count register keeps bits 15:0, and bits 31:16 read zero.
- R3: A control write that changes bit 0 from 0 to 1 starts a period. The interrupt pulse is high during the clock cycle that follows the rising edge (prescale+1)*(count+1) edges after the write edge.
- R4: With auto-reload set, each expiry starts the next period immediately, so the pulses repeat every (prescale+1)*(count+1) cycles.
- R5: With auto-reload clear, the timer gives exactly one pulse and then stops, and after that control bit 0 reads 0.
- R6: A control write that changes bit 0 from 1 to 0 stops the timer. No pulse follows.
- R7: A control write that leaves bit 0 at 1 does not restart the period in progress.
- R8: Timers 0, 1, 2 and 3 drive interrupt lines 0, 1, 9 and 10. No other line is ever high.
- R9: Prescale and count values written while a timer runs take effect only at the next start or reload.
- R10: For any period longer than one cycle, the pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, which is also the counting clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_word | input | 3 | Word address of the register |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_word (combinational) |
| irq_o | output | 11 | Interrupt request pulses, lines 0, 1, 9 and 10 used |

## Verification
The hardest case to reach from the ports is a rewrite of a running auto-reload timer. The new count and prescale values must not affect the period in progress, and the rewrite of the enable bit must not restart it. The new values must then show up in the period after the next reload. The stimulus waits for one pulse and writes the count register and the control register a few cycles later, with the enable bit still set. It then measures the next two intervals. The first interval must keep the old length and the second must have the new one. A sweep also covers every prescale and count value from 0 to 3 on every timer. It checks the exact pulse cycle, the interrupt line and the cleared enable bit each time.

// File: rtl/qtimer_pkg.sv
package qtimer_pkg;
    localparam int PRE_W   = 8;
    localparam int CNT_W   = 16;
    localparam int EN_BIT  = 0;
    localparam int RLD_BIT = 1;
    localparam int PD_LSB  = 8;

    typedef struct packed {
        logic             en;
        logic             reload;
        logic [PRE_W-1:0] pd;
        logic [CNT_W-1:0] tcv;
        logic [PRE_W-1:0] pd_act;
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] main;
        logic             pulse;
    } chan_t;
endpackage

// File: rtl/qtimer_channel.sv
module qtimer_channel
    import qtimer_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_we,
    input  logic        cnt_we,
    input  logic [15:0] wr_data,
    output logic [31:0] ctrl_rd,
    output logic [31:0] cnt_rd,
    output logic        expire_o
);
    chan_t s_q, s_d;
    logic  expire;
    logic  unused_bits;

    assign unused_bits = ^wr_data[7:2];

    always_comb begin
        s_d       = s_q;
        s_d.pulse = 1'b0;
        expire    = 1'b0;

        if (s_q.en) begin
            if (s_q.pre == '0) begin
                if (s_q.main == '0) begin
                    expire = 1'b1;
                end else begin
                    s_d.main = s_q.main - 1'b1;
                    s_d.pre  = s_q.pd_act;
                end
            end else begin
                s_d.pre = s_q.pre - 1'b1;
            end
        end

        if (expire) begin
            s_d.pulse = 1'b1;
            if (s_q.reload) begin
                s_d.pre    = s_q.pd;
                s_d.main   = s_q.tcv;
                s_d.pd_act = s_q.pd;
            end else begin
                s_d.en = 1'b0;
            end
        end

        if (cnt_we) begin
            s_d.tcv = wr_data[CNT_W-1:0];
        end

        if (ctrl_we) begin
            s_d.reload = wr_data[RLD_BIT];
            s_d.pd     = wr_data[PD_LSB +: PRE_W];
            if (wr_data[EN_BIT] && !s_q.en) begin
                s_d.en     = 1'b1;
                s_d.pre    = wr_data[PD_LSB +: PRE_W];
                s_d.pd_act = wr_data[PD_LSB +: PRE_W];
                s_d.main   = s_q.tcv;
            end else if (!wr_data[EN_BIT]) begin
                s_d.en    = 1'b0;
                s_d.pulse = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.pd     <= '1;
            s_q.pd_act <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctrl_rd  = {{(32-PD_LSB-PRE_W){1'b0}}, s_q.pd,
                       {(PD_LSB-2){1'b0}}, s_q.reload, s_q.en};
    assign cnt_rd   = {{(32-CNT_W){1'b0}}, s_q.tcv};
    assign expire_o = s_q.pulse;

    // R3: a pulse only ever follows a cycle in which a running timer sat at zero
    a_r3_pulse_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.pulse |-> $past(s_q.en && s_q.pre == '0 && s_q.main == '0));

    // R5: one-shot expiry with no competing control write clears the enable
    a_r5_oneshot_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !s_q.reload && !ctrl_we) |=> !s_q.en);

    // R6: a control write with bit 0 low leaves the timer stopped and silent
    a_r6_stop_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && !wr_data[EN_BIT]) |=> (!s_q.pulse && !s_q.en));

    // R9: the active prescale holds for the whole period in progress
    a_r9_pd_held: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.en && !expire) |=> $stable(s_q.pd_act));
endmodule

// File: rtl/quad_countdown_timer.sv
module quad_countdown_timer #(
    parameter int NUM_TIMERS = 4,
    parameter int IRQ_W      = 11,
    parameter logic [NUM_TIMERS*8-1:0] IRQ_LINES = {8'd10, 8'd9, 8'd1, 8'd0},
    localparam int IDX_W     = $clog2(NUM_TIMERS),
    localparam int ADDR_W    = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_word,
    input  logic              bus_wen,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [IRQ_W-1:0]  irq_o
);
    logic [IDX_W-1:0]  idx;
    logic              is_cnt;
    logic [31:0]       ctrl_rd [NUM_TIMERS];
    logic [31:0]       cnt_rd  [NUM_TIMERS];
    logic [NUM_TIMERS-1:0] expire;
    logic              unused_hi;

    assign idx       = bus_word[ADDR_W-1:1];
    assign is_cnt    = bus_word[0];
    assign unused_hi = ^bus_wdata[31:16];

    for (genvar k = 0; k < NUM_TIMERS; k++) begin : g_chan
        qtimer_channel i_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctrl_we  (bus_wen && !is_cnt && idx == IDX_W'(k)),
            .cnt_we   (bus_wen &&  is_cnt && idx == IDX_W'(k)),
            .wr_data  (bus_wdata[15:0]),
            .ctrl_rd  (ctrl_rd[k]),
            .cnt_rd   (cnt_rd[k]),
            .expire_o (expire[k])
        );
    end

    always_comb begin
        irq_o = '0;
        for (int k = 0; k < NUM_TIMERS; k++) begin
            irq_o[IRQ_LINES[k*8 +: 8]] = irq_o[IRQ_LINES[k*8 +: 8]] | expire[k];
        end
    end

    assign bus_rdata = is_cnt ? cnt_rd[idx] : ctrl_rd[idx];
endmodule

// File: tb/test_quad_countdown_timer.sv
module test_quad_countdown_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_word = '0;
    logic        bus_wen = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [10:0] irq_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;
    bit stray = 0;
    localparam int LINE [4] = '{0, 1, 9, 10};

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    quad_countdown_timer i_quad_countdown_timer (
        .clk(clk), .rst_n(rst_n), .bus_word(bus_word), .bus_wen(bus_wen),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_word = 3'(a); bus_wdata = d; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        @(negedge clk);
        bus_word = 3'(a);
        #1 v = bus_rdata;
    endtask

    task automatic wait_pulse(input int line, input int maxc, output int at);
        at = -1;
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if ((irq_o & ~(11'(1) << line)) != 0) stray = 1;
            if (irq_o[line]) begin
                at = cyc;
                break;
            end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int s, at, p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 irq idle", irq_o, 0);
        for (int a = 0; a < 8; a++) begin
            rd(a, v);
            check("R1 reset value", v, (a % 2 == 0) ? 32'h0000FF00 : 32'h0);
        end

        // R2: field masking and address map
        wr(3, 32'hABCD1234);
        rd(3, v); check("R2 count upper bits", v, 32'h00001234);
        rd(1, v); check("R2 other count untouched", v, 0);
        wr(6, 32'h123456FC);
        rd(6, v); check("R2 control mask", v, 32'h00005600);
        wr(6, 32'h0000FF00);

        // R3 R5 R8 R10: sweep over prescale and count 0..3 on every timer
        for (int k = 0; k < 4; k++) begin
            for (int pd = 0; pd < 4; pd++) begin
                for (int tc = 0; tc < 4; tc++) begin
                    wr(2*k+1, 32'(tc));
                    wr(2*k, 32'(pd << 8) | 32'h1);
                    s = cyc;
                    wait_pulse(LINE[k], 40, at);
                    check("R3/R8 pulse cycle on own line", at - s, (pd+1)*(tc+1));
                    @(negedge clk);
                    check("R10 pulse one cycle", irq_o[LINE[k]], 0);
                    rd(2*k, v);
                    check("R5 enable cleared after one-shot", v, 32'(pd << 8));
                end
            end
        end

        // default prescale of all ones
        wr(3, 32'h1);
        wr(2, 32'h0000FF01);
        s = cyc;
        wait_pulse(1, 600, at);
        check("R3 long prescale period", at - s, 512);

        // R4 R7 R9: auto-reload, rewrite while running
        wr(5, 32'h2);
        wr(4, 32'h0103);
        s = cyc;
        wait_pulse(9, 40, at);
        check("R4 first period", at - s, 6);
        p = at;
        wait_pulse(9, 40, at);
        check("R4 reload period", at - p, 6);
        p = at;
        wr(5, 32'h4);
        wr(4, 32'h0203);
        wait_pulse(9, 40, at);
        check("R7/R9 period unchanged by rewrite", at - p, 6);
        p = at;
        wait_pulse(9, 60, at);
        check("R9 new values after reload", at - p, 15);
        p = at;
        wait_pulse(9, 60, at);
        check("R4 repeated new period", at - p, 15);

        // R6: stop without pulse
        wr(4, 32'h0202);
        wait_pulse(9, 60, at);
        check("R6 no pulse after stop", at, -1);
        rd(4, v); check("R6 control after stop", v, 32'h0202);

        check("R8 no stray lines", stray, 0);
        finish_run();
    end
endmodule